// File: doc/BRIEF.md
# Cascade-Gated Countdown Timer

A down-counting timer driven by a small register bus. Software sets a reload value and the live count in separate registers. It then arms the timer through a control register that also holds interrupt enable, auto-disable and auto-deactivate. On every clock in which the timer is enabled, armed and allowed to run, the count drops by one. When a clock finds the count at zero, the block emits a one-cycle timeout pulse. An interrupt pulse goes with it when interrupts are enabled. The timer then reloads, stops or parks, depending on the control bits.

Three cascade inputs control whether the timer runs. Each one is picked by index from a pool of external signals and passes through a two-flop synchronizer. Cascades 0 and 1 are start conditions. Each can be enabled, inverted and set to trigger mode, and they combine by AND or OR. Cascade 2 is a stop request. In level mode it stops the timer as soon as it is active. In trigger mode it acts only when the count hits zero.

Top module: `cascade_countdown_timer`

## Requirements
- R1: After reset, every register reads zero, and `timeout_o` and `irq_o` are low.
- R2: Register map. Address 0 is control: bit0 enable, bit1 interrupt enable, bit2 auto-disable, bit3 auto-deactivate, bit4 active (read-only). Address 1 is reload. Address 2 is count. Address 3 is cascade control: bits[2:0] cascade 0, bits[5:3] cascade 1, bits[8:6] cascade 2, each field ordered {trigger, invert, enable}, and bit9 selects OR combining. Addresses 4, 5 and 6 are the source selects for cascades 0, 1 and 2, each 8 bits wide. Unused bits and addresses read zero, and reads are combinational.
- R3: A control write sets enable to bit0 and sets active to the same value. If a bus write and the timer's own update change the same register on one edge, the bus write wins. On each clock edge where enable, active and the start gate are all true and no stop is requested, the count drops by one. If that edge finds the count at zero, `timeout_o` is high for the next cycle. With neither auto mode set, the count is reloaded, so the period is reload+1 cycles.
- R4: `irq_o` pulses together with `timeout_o` only when interrupt enable was set at the terminal edge.
- R5: With auto-disable set, the terminal edge clears both enable and active, and the count stays at zero.
- R6: With auto-deactivate set and auto-disable clear, the terminal edge clears active only. Enable stays set, and counting stops until control is written again.
- R7: An enabled start cascade must be at level 1 for counting, after applying its invert bit. A change on a pool input first affects counting on the third rising edge after it is sampled. A disabled cascade has no effect.
- R8: When both start cascades are enabled, they combine by AND when bit9 is 0 and by OR when bit9 is 1.
- R9: A start cascade in trigger mode is ignored once the timer has counted at least one cycle since it was last armed.
- R10: With cascade 2 enabled and its trigger bit clear, an active cascade 2 level blocks counting and clears enable and active.
- R11: With cascade 2 enabled and its trigger bit set, an active cascade 2 has no effect until an edge finds the count at zero. That edge clears enable and active, and the count stays at zero.
- R12: Each cascade reads pool bit [index]. An index at or above the pool size reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | DATA_W (16) | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | DATA_W (16) | Combinational read data |
| src_pool | input | POOL_N (128) | Pool of external cascade sources |
| timeout_o | output | 1 | One-cycle pulse on terminal count |
| irq_o | output | 1 | Interrupt pulse, gated by interrupt enable |

## Verification
The bench goes after these corner cases:
- **Zero-count edge (R3).** A design that timed out on the step from one to zero would give a period one cycle short.
- **Auto-deactivate (R6).** A timer that dropped enable here, or that kept running, would read back the wrong control word.
- **Trigger latching (R9).** Without it, the timer would stop when the start cascade falls.
- **Cascade 2 in trigger mode (R11).** Wrongly treated as a level stop, it would halt the timer early.
- **Out-of-range source index (R12).** A design that wrapped the index would start counting when it should not.

A behavioural model predicts the read data, timeout and interrupt on every cycle, including the two-cycle synchronizer delay. Any slip in latency or priority therefore shows up as a mismatch.

// File: rtl/ctt_pkg.sv
package ctt_pkg;

    typedef enum logic [2:0] {
        A_CTRL   = 3'd0,
        A_RELOAD = 3'd1,
        A_COUNT  = 3'd2,
        A_CASC   = 3'd3,
        A_SEL0   = 3'd4,
        A_SEL1   = 3'd5,
        A_SEL2   = 3'd6
    } reg_addr_e;

    typedef struct packed {
        logic trg;
        logic inv;
        logic en;
    } casc_cfg_t;

    typedef struct packed {
        logic      or_mode;
        casc_cfg_t c2;
        casc_cfg_t c1;
        casc_cfg_t c0;
    } casc_ctrl_t;

    typedef struct packed {
        logic auto_deact;
        logic auto_dis;
        logic irq_en;
        logic enable;
    } ctrl_t;

endpackage

// File: rtl/ctt_src_select.sv
module ctt_src_select #(
    parameter int unsigned POOL_N = 128,
    parameter int unsigned SEL_W  = 8
) (
    input  logic [POOL_N-1:0] pool,
    input  logic [SEL_W-1:0]  sel,
    output logic              bit_o
);
    localparam int unsigned IDX_W = $clog2(POOL_N);

    logic [IDX_W-1:0] idx;

    always_comb begin
        idx   = sel[IDX_W-1:0];
        bit_o = 1'b0;
        if (int'(sel) < int'(POOL_N)) begin
            bit_o = pool[idx];
        end
    end
endmodule

// File: rtl/ctt_sync2.sv
module ctt_sync2 #(
    parameter int unsigned W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/ctt_core.sv
module ctt_core
    import ctt_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic              wr_reload,
    input  logic              wr_count,
    input  logic [DATA_W-1:0] wdata,
    input  casc_ctrl_t        cfg,
    input  logic [2:0]        lvl,
    output logic [DATA_W-1:0] cnt,
    output logic [DATA_W-1:0] rel,
    output ctrl_t             ctrl,
    output logic              active,
    output logic              timeout,
    output logic              irq
);
    typedef struct packed {
        logic [DATA_W-1:0] cnt;
        logic [DATA_W-1:0] rel;
        ctrl_t             ctrl;
        logic              act;
        logic              trig;
        logic              to;
        logic              irq;
    } core_st_t;

    core_st_t q, d;
    logic [2:0] lv;
    logic e0, e1, gate, stop, tick, end_stop;

    always_comb begin
        d    = q;
        d.to = 1'b0;
        lv   = lvl ^ {cfg.c2.inv, cfg.c1.inv, cfg.c0.inv};
        e0   = lv[0] | (cfg.c0.trg & q.trig);
        e1   = lv[1] | (cfg.c1.trg & q.trig);
        case ({cfg.c1.en, cfg.c0.en})
            2'b11:   gate = cfg.or_mode ? (e0 | e1) : (e0 & e1);
            2'b01:   gate = e0;
            2'b10:   gate = e1;
            default: gate = 1'b1;
        endcase
        stop     = cfg.c2.en & ~cfg.c2.trg & lv[2];
        end_stop = cfg.c2.en & cfg.c2.trg & lv[2];
        tick     = q.ctrl.enable & q.act & gate & ~stop;

        if (stop) begin
            d.ctrl.enable = 1'b0;
            d.act         = 1'b0;
            d.trig        = 1'b0;
        end
        if (tick) begin
            d.trig = 1'b1;
            if (q.cnt == '0) begin
                d.to = 1'b1;
                if (end_stop || q.ctrl.auto_dis) begin
                    d.ctrl.enable = 1'b0;
                    d.act         = 1'b0;
                    d.trig        = 1'b0;
                end else if (q.ctrl.auto_deact) begin
                    d.act  = 1'b0;
                    d.trig = 1'b0;
                end else begin
                    d.cnt = q.rel;
                end
            end else begin
                d.cnt = q.cnt - 1'b1;
            end
        end
        d.irq = d.to & q.ctrl.irq_en;

        if (wr_ctrl) begin
            d.ctrl = ctrl_t'(wdata[3:0]);
            d.act  = wdata[0];
            d.trig = 1'b0;
        end
        if (wr_reload) d.rel = wdata;
        if (wr_count)  d.cnt = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cnt     = q.cnt;
    assign rel     = q.rel;
    assign ctrl    = q.ctrl;
    assign active  = q.act;
    assign timeout = q.to;
    assign irq     = q.irq;
endmodule

// File: rtl/cascade_countdown_timer.sv
module cascade_countdown_timer
    import ctt_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned POOL_N = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [2:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [POOL_N-1:0] src_pool,
    output logic              timeout_o,
    output logic              irq_o
);
    localparam int unsigned SEL_W  = $clog2(POOL_N) + 1;
    localparam int unsigned CASC_W = $bits(casc_ctrl_t);

    typedef struct packed {
        casc_ctrl_t                casc;
        logic [2:0][SEL_W-1:0]     sel;
    } top_st_t;

    top_st_t q, d;
    logic [2:0]        raw, lvl;
    logic [DATA_W-1:0] cnt_w, rel_w;
    ctrl_t             ctrl_w;
    logic              act_w;

    always_comb begin
        d = q;
        if (wr_en) begin
            case (wr_addr)
                A_CASC: d.casc   = casc_ctrl_t'(wr_data[CASC_W-1:0]);
                A_SEL0: d.sel[0] = wr_data[SEL_W-1:0];
                A_SEL1: d.sel[1] = wr_data[SEL_W-1:0];
                A_SEL2: d.sel[2] = wr_data[SEL_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    for (genvar i = 0; i < 3; i++) begin : g_src
        ctt_src_select #(.POOL_N(POOL_N), .SEL_W(SEL_W)) u_sel (
            .pool  (src_pool),
            .sel   (q.sel[i]),
            .bit_o (raw[i])
        );
    end

    ctt_sync2 #(.W(3)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw),
        .q     (lvl)
    );

    ctt_core #(.DATA_W(DATA_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ctrl   (wr_en && (wr_addr == A_CTRL)),
        .wr_reload (wr_en && (wr_addr == A_RELOAD)),
        .wr_count  (wr_en && (wr_addr == A_COUNT)),
        .wdata     (wr_data),
        .cfg       (q.casc),
        .lvl       (lvl),
        .cnt       (cnt_w),
        .rel       (rel_w),
        .ctrl      (ctrl_w),
        .active    (act_w),
        .timeout   (timeout_o),
        .irq       (irq_o)
    );

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_CTRL:   rd_data[4:0]        = {act_w, ctrl_w};
            A_RELOAD: rd_data             = rel_w;
            A_COUNT:  rd_data             = cnt_w;
            A_CASC:   rd_data[CASC_W-1:0] = q.casc;
            A_SEL0:   rd_data[SEL_W-1:0]  = q.sel[0];
            A_SEL1:   rd_data[SEL_W-1:0]  = q.sel[1];
            A_SEL2:   rd_data[SEL_W-1:0]  = q.sel[2];
            default:  rd_data             = '0;
        endcase
    end
endmodule

// File: rtl/ctt_chk.sv
module ctt_chk #(
    parameter int unsigned DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              timeout,
    input logic              irq,
    input logic              irq_en,
    input logic              auto_dis,
    input logic              auto_deact,
    input logic              enable,
    input logic              active,
    input logic [DATA_W-1:0] cnt,
    input logic [DATA_W-1:0] rel
);
    // R4
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (timeout && $past(irq_en)));

    // R5
    auto_dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout && $past(auto_dis) && !$past(wr_en)) |-> (!enable && !active));

    // R6
    auto_deact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout && !$past(auto_dis) && $past(auto_deact) && !$past(wr_en)) |-> !active);

    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(wr_en) && (cnt != $past(cnt))) |->
            ((cnt == $past(cnt) - 1'b1) || (cnt == $past(rel))));

    // R10
    no_self_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(enable) && !$past(wr_en)) |-> !enable);

    // R3
    timeout_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> $past(enable && active));
endmodule

bind cascade_countdown_timer ctt_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .timeout    (timeout_o),
    .irq        (irq_o),
    .irq_en     (ctrl_w.irq_en),
    .auto_dis   (ctrl_w.auto_dis),
    .auto_deact (ctrl_w.auto_deact),
    .enable     (ctrl_w.enable),
    .active     (act_w),
    .cnt        (cnt_w),
    .rel        (rel_w)
);

// File: tb/cascade_countdown_timer_tb.sv
module cascade_countdown_timer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 16;
    localparam int POOL_N     = 128;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [2:0]        wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [2:0]        rd_addr = 3'd2;
    logic [DATA_W-1:0] rd_data;
    logic [POOL_N-1:0] src_pool = '0;
    logic              timeout_o, irq_o;

    cascade_countdown_timer #(.DATA_W(DATA_W), .POOL_N(POOL_N)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .src_pool(src_pool), .timeout_o(timeout_o), .irq_o(irq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    tests = 0;
    int    fails = 0;
    string cur_req = "R1";

    // behavioural reference state
    int unsigned m_cnt, m_rel, m_casc;
    int unsigned m_sel [3];
    bit m_en, m_ie, m_ad, m_adc, m_act, m_trig, m_to, m_irq;
    bit m_s1 [3];
    bit m_s2 [3];

    function automatic bit pool_bit(int unsigned idx);
        if (idx < POOL_N) return src_pool[idx];
        return 1'b0;
    endfunction

    function automatic int unsigned m_read(int unsigned a);
        case (a)
            0: return {m_act, m_adc, m_ad, m_ie, m_en};
            1: return m_rel;
            2: return m_cnt;
            3: return m_casc;
            4: return m_sel[0];
            5: return m_sel[1];
            6: return m_sel[2];
            default: return 0;
        endcase
    endfunction

    task automatic model_step();
        bit lv0, lv1, lv2, e0, e1, g, stop, endstop, tick, to;
        if (!rst_n) begin
            m_cnt = 0; m_rel = 0; m_casc = 0;
            for (int i = 0; i < 3; i++) begin m_sel[i] = 0; m_s1[i] = 0; m_s2[i] = 0; end
            {m_en, m_ie, m_ad, m_adc, m_act, m_trig, m_to, m_irq} = '0;
            return;
        end
        lv0 = m_s2[0] ^ m_casc[1];
        lv1 = m_s2[1] ^ m_casc[4];
        lv2 = m_s2[2] ^ m_casc[7];
        e0 = lv0 || (m_casc[2] && m_trig);
        e1 = lv1 || (m_casc[5] && m_trig);
        if (m_casc[0] && m_casc[3]) g = m_casc[9] ? (e0 || e1) : (e0 && e1);
        else if (m_casc[0]) g = e0;
        else if (m_casc[3]) g = e1;
        else g = 1'b1;
        stop    = m_casc[6] && !m_casc[8] && lv2;
        endstop = m_casc[6] && m_casc[8] && lv2;
        tick    = m_en && m_act && g && !stop;
        to      = 1'b0;
        m_irq   = 1'b0;
        if (stop) begin m_en = 0; m_act = 0; m_trig = 0; end
        if (tick) begin
            m_trig = 1;
            if (m_cnt == 0) begin
                to = 1;
                if (endstop || m_ad) begin m_en = 0; m_act = 0; m_trig = 0; end
                else if (m_adc) begin m_act = 0; m_trig = 0; end
                else m_cnt = m_rel;
            end else m_cnt = m_cnt - 1;
        end
        m_to  = to;
        m_irq = to && m_ie;
        for (int i = 0; i < 3; i++) begin
            m_s2[i] = m_s1[i];
            m_s1[i] = pool_bit(m_sel[i]);
        end
        if (wr_en) begin
            case (wr_addr)
                3'd0: begin
                    {m_adc, m_ad, m_ie, m_en} = wr_data[3:0];
                    m_act = wr_data[0]; m_trig = 0;
                end
                3'd1: m_rel = wr_data;
                3'd2: m_cnt = wr_data;
                3'd3: m_casc = wr_data & 16'h03FF;
                3'd4: m_sel[0] = wr_data & 16'h00FF;
                3'd5: m_sel[1] = wr_data & 16'h00FF;
                3'd6: m_sel[2] = wr_data & 16'h00FF;
                default: ;
            endcase
        end
    endtask

    always @(posedge clk) begin
        model_step();
        #(CLK_PERIOD/4);
        if (rst_n) begin
            tests++;
            if (rd_data !== m_read(rd_addr) || timeout_o !== m_to || irq_o !== m_irq) begin
                fails++;
                $display("FAIL %s cycle compare: rd[%0d]=%h to=%b irq=%b expected rd=%h to=%b irq=%b",
                         cur_req, rd_addr, rd_data, timeout_o, irq_o,
                         m_read(rd_addr), m_to, m_irq);
            end
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a[2:0]; wr_data = d[DATA_W-1:0];
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_rd(input string r, input int a, input int exp);
        @(negedge clk);
        rd_addr = a[2:0];
        #1;
        tests++;
        if (rd_data !== exp[DATA_W-1:0]) begin
            fails++;
            $display("FAIL %s read addr %0d: actual %h expected %h", r, a, rd_data, exp[DATA_W-1:0]);
        end
        rd_addr = 3'd2;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog expired during %s: actual hung expected finish", cur_req);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        // R1 reset state
        chk_rd("R1", 2, 0);
        chk_rd("R1", 0, 0);
        chk_rd("R1", 1, 0);
        // R2 register access
        cur_req = "R2";
        wr(1, 16'h1234); wr(2, 16'h0ABC); wr(3, 16'hFFFF); wr(4, 16'h01FF); wr(5, 16'h0007);
        chk_rd("R2", 1, 16'h1234);
        chk_rd("R2", 2, 16'h0ABC);
        chk_rd("R2", 3, 16'h03FF);
        chk_rd("R2", 4, 16'h00FF);
        chk_rd("R2", 5, 16'h0007);
        chk_rd("R2", 7, 0);
        wr(3, 0); wr(4, 10); wr(5, 11); wr(6, 12);
        // R3 periodic countdown
        cur_req = "R3";
        wr(1, 4); wr(2, 4); wr(0, 1);
        idle(20);
        chk_rd("R3", 0, 16'h0011);
        // R4 interrupt gating
        cur_req = "R4";
        wr(0, 3); idle(15); wr(0, 1); idle(10);
        // R5 auto-disable
        cur_req = "R5";
        wr(1, 3); wr(2, 3); wr(0, 5); idle(10);
        chk_rd("R5", 0, 16'h0004);
        chk_rd("R5", 2, 0);
        // R6 auto-deactivate
        cur_req = "R6";
        wr(2, 2); wr(0, 9); idle(10);
        chk_rd("R6", 0, 16'h0009);
        chk_rd("R6", 2, 0);
        // R7 start gating with invert
        cur_req = "R7";
        wr(1, 6); wr(2, 6); wr(3, 16'h0001); wr(0, 1);
        idle(5);
        chk_rd("R7", 2, 6);
        src_pool[10] = 1'b1; idle(6);
        src_pool[10] = 1'b0; idle(4);
        wr(3, 16'h0003); idle(5);
        // R8 AND / OR combining
        cur_req = "R8";
        wr(3, 16'h0009);
        src_pool[10] = 1'b1; idle(4);
        src_pool[11] = 1'b1; idle(5);
        src_pool[10] = 1'b0; idle(4);
        wr(3, 16'h0209); idle(5);
        src_pool[11] = 1'b0; idle(4);
        // R9 trigger latching
        cur_req = "R9";
        wr(3, 16'h0005); wr(0, 1); idle(3);
        src_pool[10] = 1'b1; idle(3);
        src_pool[10] = 1'b0; idle(10);
        chk_rd("R9", 0, 16'h0011);
        // R10 level stop on cascade 2
        cur_req = "R10";
        wr(3, 16'h0040); wr(0, 1); idle(5);
        src_pool[12] = 1'b1; idle(4);
        chk_rd("R10", 0, 0);
        // R11 cascade 2 stop only at zero
        cur_req = "R11";
        wr(3, 16'h0140); wr(1, 5); wr(2, 5); wr(0, 1); idle(3);
        chk_rd("R11", 0, 16'h0011);
        idle(10);
        chk_rd("R11", 0, 0);
        chk_rd("R11", 2, 0);
        src_pool[12] = 1'b0;
        // R12 out-of-range source index
        cur_req = "R12";
        wr(4, 200); wr(3, 16'h0001); src_pool = '1; wr(2, 3); wr(0, 1);
        idle(6);
        chk_rd("R12", 2, 3);
        src_pool = '0; wr(4, 127); src_pool[127] = 1'b1; idle(8);
        idle(2);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule